// File: doc/BRIEF.md
# Level-Sensitive Two-Output Interrupt Router

This block gathers 32 level-sensitive request lines and turns them into two interrupt outputs for a processor. Software reaches it over a plain synchronous register bus. Each access gives a registered response one cycle later. Each source has a mask bit. A mask bit is set by writing a one to the set register and cleared by writing a one to the clear register. Because of this, no read-modify-write sequence is needed and no other bit is disturbed.

The top mask bit is also the master enable for the whole block. While it is clear, nothing reaches either output. A per-source steering bit sends each unmasked request to output 0 (steering bit 0) or to output 1 (steering bit 1). Software can read the raw input levels and the masked status of each output. A service routine masks a source while it handles it, and status follows the input level directly.

Top module: `lvl_irq_router`

## Requirements
- R1: After synchronous reset every mask bit and every steering bit is 0. Both outputs are low, and reads of every register return 0.
- R2: A write to offset 0x34 sets the mask bit of every data bit written as 1 and leaves bits written as 0 unchanged. A read of offset 0x34 or 0x38 returns the current mask.
- R3: A write to offset 0x38 clears the mask bit of every data bit written as 1. Writing all ones clears the whole mask.
- R4: Mask bit 31 is the master enable. While it is 0, both status registers read 0 and both outputs stay low, whatever the inputs and the other mask bits are.
- R5: Offset 0x20 holds the steering register and reads back what was written. With the master enable set, status 0 (offset 0x00) equals raw AND mask AND NOT steering. Status 1 (offset 0x04) equals raw AND mask AND steering.
- R6: Output bit 0 is high exactly when status 0 is nonzero. Output bit 1 is high exactly when status 1 is nonzero.
- R7: Offset 0x30 returns the input levels as sampled at the previous clock edge. Status and outputs follow the levels, so dropping an input removes its request without any acknowledge.
- R8: An input level sampled at clock edge k shows at the outputs after clock edge k+1, and not before.
- R9: Writes to offsets 0x00, 0x04 and 0x30 change no state. Reads of any other offset return 0.
- R10: Every read or write gets its acknowledge one cycle later. Read data is valid in that same cycle. The acknowledge is low in the cycle after an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_ack | output | 1 | Access acknowledge, one cycle after the strobe |
| irq_in | input | 32 | Level-sensitive request lines |
| irq_out | output | 2 | Processor interrupt outputs 0 and 1 |

## Verification
All inputs high with only low mask bits set shows that the master enable alone blocks delivery. A mixed steering pattern over several enabled sources shows that the two status words split the requests without overlap. Writes with many zero bits to the set and clear registers show that untouched mask bits keep their values. Randomly interleaved set, clear, steering and level changes against a bench model exercise the AND-gating under many combinations. A directed check dropping an input confirms level following and the exact two-edge latency.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;

  localparam int OFS_W = 16;

  localparam logic [OFS_W-1:0] OFS_STAT0 = 16'h0000;
  localparam logic [OFS_W-1:0] OFS_STAT1 = 16'h0004;
  localparam logic [OFS_W-1:0] OFS_STEER = 16'h0020;
  localparam logic [OFS_W-1:0] OFS_RAW   = 16'h0030;
  localparam logic [OFS_W-1:0] OFS_SET   = 16'h0034;
  localparam logic [OFS_W-1:0] OFS_CLR   = 16'h0038;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STAT0,
    SEL_STAT1,
    SEL_STEER,
    SEL_RAW,
    SEL_SET,
    SEL_CLR
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [OFS_W-1:0] ofs);
    reg_sel_e s;
    case (ofs)
      OFS_STAT0: s = SEL_STAT0;
      OFS_STAT1: s = SEL_STAT1;
      OFS_STEER: s = SEL_STEER;
      OFS_RAW:   s = SEL_RAW;
      OFS_SET:   s = SEL_SET;
      OFS_CLR:   s = SEL_CLR;
      default:   s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import lvl_irq_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic [OFS_W-1:0] ofs,
  input  logic             wr,
  input  logic [N_SRC-1:0] wdata,
  output reg_sel_e         sel,
  output logic [N_SRC-1:0] set_bits,
  output logic [N_SRC-1:0] clr_bits,
  output logic             steer_we
);

  always_comb begin
    sel      = decode_ofs(ofs);
    set_bits = '0;
    clr_bits = '0;
    steer_we = 1'b0;
    if (wr) begin
      case (sel)
        SEL_SET:   set_bits = wdata;
        SEL_CLR:   clr_bits = wdata;
        SEL_STEER: steer_we = 1'b1;
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] set_bits,
  input  logic [N_SRC-1:0] clr_bits,
  input  logic             steer_we,
  input  logic [N_SRC-1:0] steer_wd,
  output logic [N_SRC-1:0] mask_q,
  output logic [N_SRC-1:0] steer_q
);

  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    logic en_q;
    always_ff @(posedge clk) begin
      if (rst)              en_q <= 1'b0;
      else if (clr_bits[i]) en_q <= 1'b0;
      else if (set_bits[i]) en_q <= 1'b1;
    end
    assign mask_q[i] = en_q;
  end

  always_ff @(posedge clk) begin
    if (rst)           steer_q <= '0;
    else if (steer_we) steer_q <= steer_wd;
  end

  assert_set_bits_R2: assert property (@(posedge clk) disable iff (rst)
    (|(set_bits & ~clr_bits)) |=>
      ((mask_q & $past(set_bits & ~clr_bits)) == $past(set_bits & ~clr_bits)));

  assert_clr_bits_R3: assert property (@(posedge clk) disable iff (rst)
    (|clr_bits) |=> ((mask_q & $past(clr_bits)) == '0));

  assert_untouched_R2: assert property (@(posedge clk) disable iff (rst)
    ((set_bits | clr_bits) == '0) |=> $stable(mask_q));

endmodule

// File: rtl/irq_level_route.sv
module irq_level_route #(
  parameter int N_SRC   = 32,
  parameter int GLB_BIT = N_SRC - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] irq_in,
  input  logic [N_SRC-1:0] mask_q,
  input  logic [N_SRC-1:0] steer_q,
  output logic [N_SRC-1:0] raw_q,
  output logic [N_SRC-1:0] stat0_q,
  output logic [N_SRC-1:0] stat1_q,
  output logic [1:0]       irq_out
);

  logic [N_SRC-1:0] live;
  logic [N_SRC-1:0] nxt0;
  logic [N_SRC-1:0] nxt1;

  always_comb begin
    live = mask_q[GLB_BIT] ? (raw_q & mask_q) : '0;
    nxt0 = live & ~steer_q;
    nxt1 = live & steer_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q   <= '0;
      stat0_q <= '0;
      stat1_q <= '0;
      irq_out <= '0;
    end else begin
      raw_q   <= irq_in;
      stat0_q <= nxt0;
      stat1_q <= nxt1;
      irq_out <= {|nxt1, |nxt0};
    end
  end

  assert_master_gate_R4: assert property (@(posedge clk) disable iff (rst)
    !mask_q[GLB_BIT] |=> (stat0_q == '0 && stat1_q == '0 && irq_out == 2'b00));

  assert_split_R5: assert property (@(posedge clk) disable iff (rst)
    (stat0_q & stat1_q) == '0);

  assert_within_mask_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((stat0_q | stat1_q) & ~$past(mask_q)) == '0));

  assert_out_or_R6: assert property (@(posedge clk) disable iff (rst)
    (irq_out[0] == (|stat0_q)) && (irq_out[1] == (|stat1_q)));

endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
  import lvl_irq_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd,
  input  logic             wr,
  input  reg_sel_e         sel,
  input  logic [N_SRC-1:0] stat0_q,
  input  logic [N_SRC-1:0] stat1_q,
  input  logic [N_SRC-1:0] steer_q,
  input  logic [N_SRC-1:0] raw_q,
  input  logic [N_SRC-1:0] mask_q,
  output logic [N_SRC-1:0] rdata_q,
  output logic             ack_q
);

  logic [N_SRC-1:0] mux;

  always_comb begin
    case (sel)
      SEL_STAT0:        mux = stat0_q;
      SEL_STAT1:        mux = stat1_q;
      SEL_STEER:        mux = steer_q;
      SEL_RAW:          mux = raw_q;
      SEL_SET, SEL_CLR: mux = mask_q;
      default:          mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      ack_q   <= 1'b0;
    end else begin
      ack_q   <= rd | wr;
      rdata_q <= rd ? mux : '0;
    end
  end

  assert_ack_follows_R10: assert property (@(posedge clk) disable iff (rst)
    (rd || wr) |=> ack_q);

  assert_ack_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !(rd || wr) |=> !ack_q);

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rd && sel == SEL_NONE) |=> (rdata_q == '0));

endmodule

// File: rtl/lvl_irq_router.sv
module lvl_irq_router
  import lvl_irq_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [N_SRC-1:0]  bus_wdata,
  output logic [N_SRC-1:0]  bus_rdata,
  output logic              bus_ack,
  input  logic [N_SRC-1:0]  irq_in,
  output logic [1:0]        irq_out
);

  localparam int GLB_BIT = N_SRC - 1;

  reg_sel_e         sel;
  logic [N_SRC-1:0] set_bits;
  logic [N_SRC-1:0] clr_bits;
  logic             steer_we;
  logic [N_SRC-1:0] mask_q;
  logic [N_SRC-1:0] steer_q;
  logic [N_SRC-1:0] raw_q;
  logic [N_SRC-1:0] stat0_q;
  logic [N_SRC-1:0] stat1_q;

  irq_bus_decode #(.N_SRC(N_SRC)) u_dec (
    .ofs      (OFS_W'(bus_addr)),
    .wr       (bus_wr),
    .wdata    (bus_wdata),
    .sel      (sel),
    .set_bits (set_bits),
    .clr_bits (clr_bits),
    .steer_we (steer_we)
  );

  irq_mask_bank #(.N_SRC(N_SRC)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .set_bits (set_bits),
    .clr_bits (clr_bits),
    .steer_we (steer_we),
    .steer_wd (bus_wdata),
    .mask_q   (mask_q),
    .steer_q  (steer_q)
  );

  irq_level_route #(.N_SRC(N_SRC), .GLB_BIT(GLB_BIT)) u_route (
    .clk     (clk),
    .rst     (rst),
    .irq_in  (irq_in),
    .mask_q  (mask_q),
    .steer_q (steer_q),
    .raw_q   (raw_q),
    .stat0_q (stat0_q),
    .stat1_q (stat1_q),
    .irq_out (irq_out)
  );

  irq_read_port #(.N_SRC(N_SRC)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd      (bus_rd),
    .wr      (bus_wr),
    .sel     (sel),
    .stat0_q (stat0_q),
    .stat1_q (stat1_q),
    .steer_q (steer_q),
    .raw_q   (raw_q),
    .mask_q  (mask_q),
    .rdata_q (bus_rdata),
    .ack_q   (bus_ack)
  );

  assert_status_write_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (sel == SEL_STAT0 || sel == SEL_STAT1 || sel == SEL_RAW))
      |=> ($stable(mask_q) && $stable(steer_q)));

endmodule

// File: tb/test_lvl_irq_router.sv
module test_lvl_irq_router;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ack;
  logic [31:0] irq_in = '0;
  logic [1:0]  irq_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_mask = '0;
  logic [31:0] m_steer = '0;

  always #10 clk = ~clk;

  lvl_irq_router i_lvl_irq_router (
    .clk, .rst, .bus_addr, .bus_wr, .bus_rd, .bus_wdata,
    .bus_rdata, .bus_ack, .irq_in, .irq_out
  );

  function automatic logic [31:0] f_stat0(logic [31:0] r, logic [31:0] m, logic [31:0] t);
    return m[31] ? (r & m & ~t) : 32'h0;
  endfunction

  function automatic logic [31:0] f_stat1(logic [31:0] r, logic [31:0] m, logic [31:0] t);
    return m[31] ? (r & m & t) : 32'h0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
    if (a == 8'h34) m_mask = m_mask | d;
    else if (a == 8'h38) m_mask = m_mask & ~d;
    else if (a == 8'h20) m_steer = d;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check("R10 ack", {31'b0, bus_ack}, 32'h1);
    d = bus_rdata;
  endtask

  task automatic verify_all();
    logic [31:0] d;
    repeat (3) @(negedge clk);
    bus_read(8'h34, d); check("R2 mask at set offset", d, m_mask);
    bus_read(8'h38, d); check("R2 mask at clear offset", d, m_mask);
    bus_read(8'h20, d); check("R5 steering", d, m_steer);
    bus_read(8'h30, d); check("R7 raw", d, irq_in);
    bus_read(8'h00, d); check("R5 status0", d, f_stat0(irq_in, m_mask, m_steer));
    bus_read(8'h04, d); check("R5 status1", d, f_stat1(irq_in, m_mask, m_steer));
    check("R6 outputs", {30'b0, irq_out},
          {30'b0, |f_stat1(irq_in, m_mask, m_steer), |f_stat0(irq_in, m_mask, m_steer)});
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 outputs", {30'b0, irq_out}, 32'h0);
    bus_read(8'h34, d); check("R1 mask", d, 32'h0);
    bus_read(8'h20, d); check("R1 steering", d, 32'h0);
    bus_read(8'h00, d); check("R1 status0", d, 32'h0);
    @(negedge clk);
    check("R10 idle ack", {31'b0, bus_ack}, 32'h0);

    // R4 master enable off blocks everything
    irq_in = 32'hFFFF_FFFF;
    bus_write(8'h34, 32'h0000_00F0);
    verify_all();
    check("R4 outputs low without master", {30'b0, irq_out}, 32'h0);

    // R2 set keeps untouched bits
    bus_write(8'h34, 32'h8000_000F);
    verify_all();
    check("R2 mask accumulates", m_mask, 32'h8000_00FF);
    check("R6 out0 high", {31'b0, irq_out[0]}, 32'h1);

    // R5 steering split
    bus_write(8'h20, 32'h0000_0003);
    verify_all();
    bus_read(8'h04, d); check("R5 status1 value", d, 32'h0000_0003);
    bus_read(8'h00, d); check("R5 status0 value", d, 32'h8000_00FC);

    // R7 level following
    irq_in = 32'h0;
    verify_all();
    check("R7 outputs drop", {30'b0, irq_out}, 32'h0);
    irq_in = 32'h0000_0010;

    // R9 ignored writes and unmapped reads
    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_write(8'h04, 32'hFFFF_FFFF);
    bus_write(8'h30, 32'hFFFF_FFFF);
    verify_all();
    bus_read(8'h34, d); check("R9 mask untouched", d, 32'h8000_00FF);
    bus_read(8'h20, d); check("R9 steering untouched", d, 32'h0000_0003);
    bus_read(8'h10, d); check("R9 unmapped read", d, 32'h0);

    // R3 clear
    bus_write(8'h38, 32'h0000_0001);
    verify_all();
    check("R3 single clear", m_mask, 32'h8000_00FE);
    bus_write(8'h38, 32'hFFFF_FFFF);
    verify_all();
    bus_read(8'h38, d); check("R3 clear all", d, 32'h0);

    // R8 latency
    irq_in = 32'h0;
    bus_write(8'h20, 32'h0);
    bus_write(8'h34, 32'h8000_0001);
    repeat (3) @(negedge clk);
    irq_in = 32'h1;
    @(negedge clk);
    check("R8 not before second edge", {31'b0, irq_out[0]}, 32'h0);
    @(negedge clk);
    check("R8 after second edge", {31'b0, irq_out[0]}, 32'h1);

    // random mix
    for (int it = 0; it < 150; it++) begin
      int unsigned op = $urandom % 4;
      logic [31:0] v = $urandom;
      case (op)
        0: bus_write(8'h34, v | (($urandom % 3 != 0) ? 32'h8000_0000 : 32'h0));
        1: bus_write(8'h38, v & $urandom & $urandom);
        2: bus_write(8'h20, v);
        default: irq_in = v;
      endcase
      verify_all();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule